// File: doc/BRIEF.md
# Peripheral DMA request arbiter

This block sits between a set of peripheral DMA channels and a single system-bus port. Each peripheral raises receive and transmit transfer requests. The arbiter records them and hands the bus to exactly one request at a time. The granted channel then gets the bus and performs its read-then-write transfer. When the bus side signals completion, the grant is released and the next request is served.

Requests are served strictly in the order in which they arrive. Fixed priority and round-robin are not used. Direction and peripheral index only decide the order among requests captured on the same clock edge. Receive requests go ahead of transmit requests, and within one direction the lower peripheral index goes first. Each channel direction has at most one request outstanding, so the arrival queue never needs more entries than there are request sources.

Top module: `dma_req_arbiter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, every grant output is low.
- R2: Requests captured on different clock edges are granted in the order in which they were captured.
- R3: Among requests captured on the same edge, every receive request is granted before any transmit request.
- R4: Among same-direction requests captured on the same edge, the lower peripheral index is granted first. Requests are numbered as follows: receive index i is source i, and transmit index i is source N_PERIPH+i. Together with R3, simultaneous sources are served in ascending source number.
- R5: At most one grant bit across both grant outputs is high at any time. A grant stays unchanged until `done_i` is sampled high.
- R6: When `done_i` is sampled high with a grant active, all grants are low for exactly one cycle. If requests are queued, the oldest one is granted on the following edge.
- R7: A request from a channel direction that is already pending is ignored. A source is pending from the edge that captures it up to and including the cycle in which its `done_i` is sampled. It is not granted a second time.
- R8: `done_i` sampled high while no grant is active has no effect.
- R9: With the arbiter idle and the queue empty, a request sampled on edge e is visible as a grant after edge e+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_req_i | input | N_PERIPH | Receive transfer request, one bit per peripheral |
| tx_req_i | input | N_PERIPH | Transmit transfer request, one bit per peripheral |
| done_i | input | 1 | Transfer complete for the active grant |
| rx_gnt_o | output | N_PERIPH | Receive grant, one bit per peripheral |
| tx_gnt_o | output | N_PERIPH | Transmit grant, one bit per peripheral |

## Verification
The bench builds the arbiter with N_PERIPH=3. This gives six request sources and an arrival queue that is rounded up to eight entries, so its pointers wrap while the queue is in use. The small size lets the bench apply all 63 non-empty sets of simultaneous requests and check each served order against ascending source number. It also issues every ordering generated by stepping through five sources with strides 1 to 4 and all offsets, one request per cycle behind an active grant. These sweeps are followed by directed cases for requests repeated while pending, completion pulses while idle, and grant latency.

// File: rtl/dra_pkg.sv
package dra_pkg;
  // queue depth: next power of two at or above the number of sources
  function automatic int unsigned dra_depth(input int unsigned n_ids);
    return 1 << $clog2(n_ids);
  endfunction
endpackage

// File: rtl/dra_capture.sv
module dra_capture #(
  parameter int unsigned N_IDS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IDS-1:0] req_i,
  input  logic [N_IDS-1:0] clr_i,
  output logic [N_IDS-1:0] push_o,
  output logic [N_IDS-1:0] pend_o
);
  logic [N_IDS-1:0] pend_q;

  // a source already pending (incl. its done cycle) is not captured again
  assign push_o = req_i & ~pend_q;
  assign pend_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q | push_o) & ~clr_i;
  end
endmodule

// File: rtl/dra_order_fifo.sv
module dra_order_fifo
  import dra_pkg::*;
#(
  parameter int unsigned N_IDS = 8,
  parameter int unsigned ID_W  = 3,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IDS-1:0] push_i,
  input  logic             pop_i,
  output logic             empty_o,
  output logic [ID_W-1:0]  head_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int unsigned DEPTH = dra_depth(N_IDS);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ID_W-1:0]  mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PTR_W-1:0] slot [N_IDS];
  logic [CNT_W-1:0] n_push;

  // same-edge arrivals take consecutive slots in ascending source order
  always_comb begin
    n_push = '0;
    for (int i = 0; i < N_IDS; i++) begin
      slot[i] = wr_q + PTR_W'(n_push);
      n_push  = n_push + CNT_W'(push_i[i]);
    end
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < N_IDS; i++)
      if (push_i[i]) mem_q[slot[i]] <= ID_W'(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_q + PTR_W'(n_push);
      rd_q  <= rd_q + PTR_W'(pop_i);
      cnt_q <= cnt_q + n_push - CNT_W'(pop_i);
    end
  end

  assign empty_o = (cnt_q == '0);
  assign head_o  = mem_q[rd_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/dra_grant.sv
module dra_grant #(
  parameter int unsigned N_IDS = 8,
  parameter int unsigned ID_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             empty_i,
  input  logic [ID_W-1:0]  head_i,
  input  logic             done_i,
  output logic             pop_o,
  output logic [N_IDS-1:0] gnt_o,
  output logic [N_IDS-1:0] clr_o
);
  localparam logic [N_IDS-1:0] ONE = N_IDS'(1);

  logic             busy_q;
  logic [N_IDS-1:0] gnt_q;

  // issue only from idle; the done edge returns to idle, giving a one-cycle gap
  assign pop_o = !busy_q && !empty_i;
  assign clr_o = (busy_q && done_i) ? gnt_q : '0;
  assign gnt_o = gnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      gnt_q  <= '0;
    end else if (pop_o) begin
      busy_q <= 1'b1;
      gnt_q  <= ONE << head_i;
    end else if (busy_q && done_i) begin
      busy_q <= 1'b0;
      gnt_q  <= '0;
    end
  end
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
  parameter int unsigned N_PERIPH = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_PERIPH-1:0] rx_req_i,
  input  logic [N_PERIPH-1:0] tx_req_i,
  input  logic                done_i,
  output logic [N_PERIPH-1:0] rx_gnt_o,
  output logic [N_PERIPH-1:0] tx_gnt_o
);
  localparam int unsigned N_IDS = 2 * N_PERIPH;
  localparam int unsigned ID_W  = $clog2(N_IDS);
  localparam int unsigned CNT_W = $clog2(dra_pkg::dra_depth(N_IDS)) + 1;

  logic [N_IDS-1:0] req_w, push_w, pend_w, clr_w, gnt_w;
  logic             pop_w, empty_w;
  logic [ID_W-1:0]  head_w;
  logic [CNT_W-1:0] fifo_cnt_w;

  // source number: receive i -> i, transmit i -> N_PERIPH+i
  assign req_w = {tx_req_i, rx_req_i};

  dra_capture #(.N_IDS(N_IDS)) u_capture (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_w),
    .clr_i  (clr_w),
    .push_o (push_w),
    .pend_o (pend_w)
  );

  dra_order_fifo #(.N_IDS(N_IDS), .ID_W(ID_W), .CNT_W(CNT_W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push_w),
    .pop_i   (pop_w),
    .empty_o (empty_w),
    .head_o  (head_w),
    .count_o (fifo_cnt_w)
  );

  dra_grant #(.N_IDS(N_IDS), .ID_W(ID_W)) u_grant (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .empty_i (empty_w),
    .head_i  (head_w),
    .done_i  (done_i),
    .pop_o   (pop_w),
    .gnt_o   (gnt_w),
    .clr_o   (clr_w)
  );

  assign rx_gnt_o = gnt_w[N_PERIPH-1:0];
  assign tx_gnt_o = gnt_w[N_IDS-1:N_PERIPH];
endmodule

// File: rtl/dra_arb_checker.sv
module dra_arb_checker #(
  parameter int unsigned N_IDS = 8,
  parameter int unsigned CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             done_i,
  input logic [N_IDS-1:0] gnt_i,
  input logic [N_IDS-1:0] pend_i,
  input logic [CNT_W-1:0] cnt_i
);
  assert_gnt_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_i));

  assert_gnt_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_i != '0 && !done_i) |=> $stable(gnt_i));

  assert_gnt_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_i != '0 && done_i) |=> gnt_i == '0);

  assert_gnt_pending_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_i & ~pend_i) == '0);

  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_i) <= N_IDS);

  // every pending source is either queued or holds the grant
  assert_queue_track_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_i) + int'(gnt_i != '0) == $countones(pend_i));
endmodule

bind dma_req_arbiter dra_arb_checker #(.N_IDS(N_IDS), .CNT_W(CNT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .done_i (done_i),
  .gnt_i  (gnt_w),
  .pend_i (pend_w),
  .cnt_i  (fifo_cnt_w)
);

// File: tb/dma_req_arbiter_tb.sv
module dma_req_arbiter_tb;
  localparam int NP = 3;
  localparam int NI = 2 * NP;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] rx_req = '0, tx_req = '0;
  logic          done = 1'b0;
  logic [NP-1:0] rx_gnt, tx_gnt;
  int            n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  dma_req_arbiter #(.N_PERIPH(NP)) u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .rx_req_i (rx_req),
    .tx_req_i (tx_req),
    .done_i   (done),
    .rx_gnt_o (rx_gnt),
    .tx_gnt_o (tx_gnt)
  );

  function automatic logic [NI-1:0] g();
    return {tx_gnt, rx_gnt};
  endfunction

  function automatic logic [NI-1:0] bit_of(input int id);
    return NI'(1) << id;
  endfunction

  task automatic chk(input string tag, input logic [NI-1:0] act, input logic [NI-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  // called at a negedge; request sampled on the next posedge
  task automatic pulse_req(input logic [NI-1:0] v);
    {tx_req, rx_req} = v;
    @(negedge clk);
    {tx_req, rx_req} = '0;
  endtask

  // grant for id expected now; hold, complete, check gap
  task automatic serve(input int id, input int hold, input string tag);
    chk(tag, g(), bit_of(id));
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R5 grant held", g(), bit_of(id));
    end
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk("R6 one-cycle gap", g(), '0);
    @(negedge clk);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    report();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 grants low in reset", g(), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 grants low after reset", g(), '0);

    // R3/R4: every set of simultaneous sources served in ascending source number
    for (int m = 1; m < (1 << NI); m++) begin
      pulse_req(NI'(m));
      chk("R9 no grant one edge after request", g(), '0);
      @(negedge clk);
      for (int id = 0; id < NI; id++)
        if (m[id]) serve(id, id % 3, "R3/R4 same-edge order");
      chk("R3/R4 queue drained", g(), '0);
    end

    // R2: one request per cycle behind an active grant, drained in issue order
    for (int s = 1; s <= 4; s++) begin
      for (int off = 0; off < 5; off++) begin
        pulse_req(bit_of(5));
        @(negedge clk);
        chk("R2 first grant", g(), bit_of(5));
        for (int k = 0; k < 5; k++) begin
          {tx_req, rx_req} = bit_of((k * s + off) % 5);
          @(negedge clk);
          chk("R5 grant held while queuing", g(), bit_of(5));
        end
        {tx_req, rx_req} = '0;
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        chk("R6 gap after first", g(), '0);
        @(negedge clk);
        for (int k = 0; k < 5; k++)
          serve((k * s + off) % 5, k % 2, "R2 arrival order");
        chk("R2 queue drained", g(), '0);
      end
    end

    // R7: repeated request while pending, including in the done cycle
    pulse_req(bit_of(1));
    @(negedge clk);
    chk("R7 setup grant", g(), bit_of(1));
    rx_req = 3'b010;
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    rx_req = '0;
    chk("R7 gap", g(), '0);
    @(negedge clk);
    chk("R7 repeat ignored", g(), '0);
    @(negedge clk);
    chk("R7 repeat ignored later", g(), '0);
    pulse_req(bit_of(1));
    @(negedge clk);
    serve(1, 0, "R7 accepted after completion");

    // R8: done while idle has no effect
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk("R8 idle done no grant", g(), '0);
    @(negedge clk);
    chk("R8 idle done still no grant", g(), '0);
    pulse_req(bit_of(4));
    chk("R9 latency edge e", g(), '0);
    @(negedge clk);
    serve(4, 1, "R9/R8 grant after edge e+1");
    chk("R8 final idle", g(), '0);

    report();
  end
endmodule